// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

An eight-bit storage register that, on each rising clock edge, either keeps its value, moves its contents one place toward the high or the low end, takes a new word from a parallel bus, or clears to zero. The parallel bus is bidirectional: the same lines carry the register contents out and the load word in. The block presents this bus as three signals: an outgoing data vector, an incoming data vector and one drive-enable. A wrapper at the chip edge turns those into a tri-state port.

Two serial inputs feed the ends of the register, one for each shift direction. Two serial outputs always show the lowest and the highest bit, so that several registers can be chained into a longer word. Bus driving needs both active-low enables asserted. It is also cut off whenever the mode select asks for a load, so that an external source can put data on the lines. The enables act only on the bus driver. The register keeps shifting, loading and clearing while the bus is released.

Top module: `uni_shift_reg`

## Requirements
- R1: When `rstN` is low at a rising clock edge, every register bit becomes 0, whatever `modeSel` holds.
- R2: With `rstN` high and `modeSel` = 2'b11, the register takes the value of `busIn` at the rising edge.
- R3: With `rstN` high and `modeSel` = 2'b01, bit 0 takes `serInRight` and each bit i (i ≥ 1) takes the old bit i-1 at the rising edge.
- R4: With `rstN` high and `modeSel` = 2'b10, bit 7 takes `serInLeft` and each bit i (i ≤ 6) takes the old bit i+1 at the rising edge.
- R5: With `rstN` high and `modeSel` = 2'b00, the register keeps its value across the rising edge.
- R6: `busDriveEn` is high only when both bits of `oeN` are low; a high on either bit forces it low.
- R7: `busDriveEn` is low whenever `modeSel` = 2'b11, even with both enables low.
- R8: Clear, load, shift and hold act on the register exactly as in R1 to R5 while `busDriveEn` is low.
- R9: `busOut` always carries the register contents, `serOutLow` always equals bit 0 and `serOutHigh` always equals bit 7, whatever the enable state.
- R10: `busIn`, `modeSel` and the serial inputs are sampled only at the rising edge; changes between edges, and `busIn` in any mode other than load, leave the stored value untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous clear, active low, overrides the mode |
| modeSel | input | 2 | Operation: 00 hold, 01 shift toward bit 7, 10 shift toward bit 0, 11 load |
| serInRight | input | 1 | Serial bit entering bit 0 in mode 01 |
| serInLeft | input | 1 | Serial bit entering bit 7 in mode 10 |
| oeN | input | 2 | Bus output enables, both must be low to drive |
| busIn | input | 8 | Incoming side of the shared bus, used in load mode |
| busOut | output | 8 | Outgoing side of the shared bus, the register contents |
| busDriveEn | output | 1 | High when the wrapper should drive `busOut` onto the bus |
| serOutLow | output | 1 | Bit 0 of the register |
| serOutHigh | output | 1 | Bit 7 of the register |

## Verification
The assertions assume that the register is cleared before any mode result matters. The register holds an arbitrary value until the first clear, so every data property is disabled while `rstN` is low, and the bench holds `rstN` low over the first edges. The properties also assume that inputs are stable at each rising edge. The bench drives every input on the falling edge, and in the between-edge test it toggles inputs only well away from the rising edge.

// File: rtl/uni_shift_reg_pkg.sv
package uni_shift_reg_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_UP    = 2'b01,
    MODE_DOWN  = 2'b10,
    MODE_LOAD  = 2'b11
  } modeE;

  typedef struct packed {
    logic clear;
    logic load;
    logic shiftUp;
    logic shiftDown;
    logic drive;
  } ctrlS;

endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import uni_shift_reg_pkg::*;
#(
  parameter int NUM_OE = 2
) (
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [NUM_OE-1:0] oeN,
  output ctrlS              ctrl
);

  modeE mode;
  logic enablesOn;

  assign mode      = modeE'(modeSel);
  assign enablesOn = ~|oeN;

  always_comb begin
    ctrl           = '0;
    ctrl.clear     = ~rstN;
    if (rstN) begin
      unique case (mode)
        MODE_LOAD: ctrl.load      = 1'b1;
        MODE_UP:   ctrl.shiftUp   = 1'b1;
        MODE_DOWN: ctrl.shiftDown = 1'b1;
        default:   ;
      endcase
    end
    ctrl.drive = enablesOn && (mode != MODE_LOAD);
  end

endmodule

// File: rtl/usr_datapath.sv
module usr_datapath
  import uni_shift_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  ctrlS             ctrl,
  input  logic             serInRight,
  input  logic             serInLeft,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] regQ
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] regNext;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromBelow;
    logic fromAbove;

    if (i == 0) begin : g_low
      assign fromBelow = serInRight;
    end else begin : g_lowMid
      assign fromBelow = regQ[i-1];
    end

    if (i == TOP) begin : g_high
      assign fromAbove = serInLeft;
    end else begin : g_highMid
      assign fromAbove = regQ[i+1];
    end

    always_comb begin
      if (ctrl.clear)          regNext[i] = 1'b0;
      else if (ctrl.load)      regNext[i] = busIn[i];
      else if (ctrl.shiftUp)   regNext[i] = fromBelow;
      else if (ctrl.shiftDown) regNext[i] = fromAbove;
      else                     regNext[i] = regQ[i];
    end
  end

  always_ff @(posedge clk) begin
    regQ <= regNext;
  end

endmodule

// File: rtl/uni_shift_reg.sv
module uni_shift_reg
  import uni_shift_reg_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int NUM_OE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              serInRight,
  input  logic              serInLeft,
  input  logic [NUM_OE-1:0] oeN,
  input  logic [WIDTH-1:0]  busIn,
  output logic [WIDTH-1:0]  busOut,
  output logic              busDriveEn,
  output logic              serOutLow,
  output logic              serOutHigh
);

  ctrlS             ctrl;
  logic [WIDTH-1:0] regQ;

  usr_ctrl #(.NUM_OE(NUM_OE)) u_ctrl (
    .rstN    (rstN),
    .modeSel (modeSel),
    .oeN     (oeN),
    .ctrl    (ctrl)
  );

  usr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .ctrl       (ctrl),
    .serInRight (serInRight),
    .serInLeft  (serInLeft),
    .busIn      (busIn),
    .regQ       (regQ)
  );

  assign busOut     = regQ;
  assign busDriveEn = ctrl.drive;
  assign serOutLow  = regQ[0];
  assign serOutHigh = regQ[WIDTH-1];

endmodule

// File: rtl/uni_shift_reg_checker.sv
module uni_shift_reg_checker #(
  parameter int WIDTH  = 8,
  parameter int NUM_OE = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              serInRight,
  input logic              serInLeft,
  input logic [NUM_OE-1:0] oeN,
  input logic [WIDTH-1:0]  busIn,
  input logic [WIDTH-1:0]  busOut,
  input logic              busDriveEn,
  input logic              serOutLow,
  input logic              serOutHigh
);

  assert_clear_R1: assert property (@(posedge clk)
    !rstN |=> busOut == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 2'b11 |=> busOut == $past(busIn));

  assert_shift_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 2'b01 |=> busOut == {$past(busOut[WIDTH-2:0]), $past(serInRight)});

  assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 2'b10 |=> busOut == {$past(serInLeft), $past(busOut[WIDTH-1:1])});

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 2'b00 |=> $stable(busOut));

  assert_enable_gate_R6: assert property (@(posedge clk)
    (|oeN) |-> !busDriveEn);

  assert_load_release_R7: assert property (@(posedge clk)
    modeSel == 2'b11 |-> !busDriveEn);

  assert_serial_taps_R9: assert property (@(posedge clk)
    serOutLow == busOut[0] && serOutHigh == busOut[WIDTH-1]);

endmodule

bind uni_shift_reg uni_shift_reg_checker #(.WIDTH(WIDTH), .NUM_OE(NUM_OE)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .serInRight (serInRight),
  .serInLeft  (serInLeft),
  .oeN        (oeN),
  .busIn      (busIn),
  .busOut     (busOut),
  .busDriveEn (busDriveEn),
  .serOutLow  (serOutLow),
  .serOutHigh (serOutHigh)
);

// File: tb/uni_shift_reg_bench.sv
module uni_shift_reg_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] modeSel;
  logic       serInRight;
  logic       serInLeft;
  logic [1:0] oeN;
  logic [7:0] busIn;
  logic [7:0] busOut;
  logic       busDriveEn;
  logic       serOutLow;
  logic       serOutHigh;

  int checks = 0;
  int errors = 0;
  logic [7:0] model;

  always #10 clk = ~clk;

  uni_shift_reg u_uni_shift_reg (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .serInRight (serInRight),
    .serInLeft  (serInLeft),
    .oeN        (oeN),
    .busIn      (busIn),
    .busOut     (busOut),
    .busDriveEn (busDriveEn),
    .serOutLow  (serOutLow),
    .serOutHigh (serOutHigh)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, clock once, sample 2 ns after the rising edge
  task automatic step(input logic r, input logic [1:0] m, input logic sr,
                      input logic sl, input logic [7:0] d);
    @(negedge clk);
    rstN = r; modeSel = m; serInRight = sr; serInLeft = sl; busIn = d;
    @(posedge clk);
    #2;
  endtask

  task automatic testReset();
    step(1'b0, 2'b11, 1'b1, 1'b1, 8'hFF);
    model = 8'h00;
    check("R1 clear over load", busOut, model);
    step(1'b1, 2'b11, 1'b0, 1'b0, 8'h5A);
    step(1'b0, 2'b01, 1'b1, 1'b1, 8'hFF);
    check("R1 clear over shift", busOut, 8'h00);
  endtask

  task automatic testLoad();
    step(1'b1, 2'b11, 1'b0, 1'b0, 8'hA5);
    check("R2 load A5", busOut, 8'hA5);
    step(1'b1, 2'b11, 1'b1, 1'b1, 8'h3C);
    check("R2 load 3C", busOut, 8'h3C);
    model = 8'h3C;
  endtask

  task automatic testShiftUp();
    step(1'b1, 2'b11, 1'b0, 1'b0, 8'h81);
    model = 8'h81;
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = (i % 2 == 0);
      step(1'b1, 2'b01, b, ~b, 8'hFF);
      model = {model[6:0], b};
      check("R3 shift toward bit 7", busOut, model);
    end
  endtask

  task automatic testShiftDown();
    step(1'b1, 2'b11, 1'b0, 1'b0, 8'h81);
    model = 8'h81;
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = (i < 2);
      step(1'b1, 2'b10, ~b, b, 8'h00);
      model = {b, model[7:1]};
      check("R4 shift toward bit 0", busOut, model);
    end
  endtask

  task automatic testHold();
    step(1'b1, 2'b11, 1'b0, 1'b0, 8'h96);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 2'b00, 1'b1, 1'b1, 8'h69 + 8'(i));
      check("R5 hold, R10 bus ignored", busOut, 8'h96);
    end
  endtask

  task automatic testDrive();
    @(negedge clk);
    modeSel = 2'b00;
    for (int e = 0; e < 4; e++) begin
      oeN = 2'(e);
      #1;
      check("R6 enables gate drive", {7'b0, busDriveEn}, {7'b0, e == 0});
    end
    oeN = 2'b00; modeSel = 2'b01;
    #1;
    check("R6 drive in shift", {7'b0, busDriveEn}, 8'h01);
    modeSel = 2'b11;
    #1;
    check("R7 released in load", {7'b0, busDriveEn}, 8'h00);
    modeSel = 2'b00;
  endtask

  task automatic testDisabledOps();
    @(negedge clk);
    oeN = 2'b11;
    step(1'b1, 2'b11, 1'b0, 1'b0, 8'hC3);
    check("R8 load while released", busOut, 8'hC3);
    step(1'b1, 2'b01, 1'b1, 1'b0, 8'h00);
    check("R8 shift while released", busOut, 8'h87);
    step(1'b1, 2'b10, 1'b0, 1'b1, 8'h00);
    check("R8 shift down while released", busOut, 8'hC3);
    step(1'b1, 2'b00, 1'b0, 1'b0, 8'h00);
    check("R8 hold while released", busOut, 8'hC3);
    step(1'b0, 2'b00, 1'b0, 1'b0, 8'h00);
    check("R8 clear while released", busOut, 8'h00);
    check("R8 drive off", {7'b0, busDriveEn}, 8'h00);
    oeN = 2'b00;
  endtask

  task automatic testSerialTaps();
    logic [7:0] pats [4] = '{8'h01, 8'h80, 8'hFF, 8'h7E};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      oeN = 2'(i);
      step(1'b1, 2'b11, 1'b0, 1'b0, pats[i]);
      check("R9 taps", {6'b0, serOutHigh, serOutLow}, {6'b0, pats[i][7], pats[i][0]});
    end
    oeN = 2'b00;
  endtask

  task automatic testBetweenEdges();
    step(1'b1, 2'b11, 1'b0, 1'b0, 8'h5A);
    step(1'b1, 2'b00, 1'b0, 1'b0, 8'h00);
    // glitch inputs in the middle of the high phase
    #3;
    modeSel = 2'b11; busIn = 8'hFF; serInRight = 1'b1; serInLeft = 1'b1;
    #2;
    modeSel = 2'b01;
    #2;
    modeSel = 2'b00;
    @(negedge clk);
    #2;
    check("R10 mid-cycle glitch ignored", busOut, 8'h5A);
    step(1'b1, 2'b00, 1'b1, 1'b1, 8'hFF);
    check("R10 hold after glitch", busOut, 8'h5A);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    rstN = 1'b0; modeSel = 2'b00; serInRight = 1'b0; serInLeft = 1'b0;
    oeN = 2'b00; busIn = 8'h00; model = 8'h00;
    repeat (2) @(posedge clk);
    testReset();
    testLoad();
    testShiftUp();
    testShiftDown();
    testHold();
    testDrive();
    testDisabledOps();
    testSerialTaps();
    testBetweenEdges();
    finishRun();
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule